// File: doc/BRIEF.md
# ECC Error Aggregator

This block collects error reports from a set of ECC-protected endpoints, such as memories or interconnect checkers, and combines them into two level interrupts. One interrupt covers correctable errors and the other covers uncorrectable errors. Each endpoint has its own report lane. A report carries a valid strobe, a single-bit flag, a double-bit flag, a parity-only flag, an address and a bit-location field. An endpoint that is protected only by parity cannot correct anything, so any error it reports is treated as uncorrectable.

For each endpoint the aggregator keeps a small record: a correctable-pending bit, an uncorrectable-pending bit, the address and bit field of the first error since the last clear, and a saturating count of reports. Software sees a record through an index-selected read port. It clears a record with an indexed clear strobe and writes a per-endpoint interrupt enable mask. The enable mask only gates the interrupts. Records keep updating while their endpoint is masked.

Top module: `ecc_err_agg`

## Requirements
- R1: A valid report with the single-bit flag set and the parity flag clear sets the endpoint's correctable-pending bit on the next clock edge.
- R2: A valid report with the double-bit flag set sets the endpoint's uncorrectable-pending bit on the next clock edge.
- R3: A valid report with the parity flag set sets only the uncorrectable-pending bit, whatever its single and double flags are, and never the correctable-pending bit.
- R4: A report with both the single-bit and double-bit flags set, and the parity flag clear, sets both pending bits in the same edge.
- R5: The address and bit field are captured from the first report that reaches an endpoint with neither pending bit set. Later reports leave them unchanged until a clear.
- R6: Every valid report that sets a pending bit increments the endpoint's count. The count saturates at 2^CNT_W-1 (7 by default).
- R7: A clear strobe zeroes the indexed endpoint's record on the next edge. A report arriving in the same cycle as the clear is recorded as a first error.
- R8: irq_ce is the OR of the correctable-pending bits of the enabled endpoints, and irq_ue is the same for the uncorrectable-pending bits. A pending bit raised while its endpoint is masked asserts the interrupt as soon as the mask bit is written to 1.
- R9: An interrupt stays asserted while its pending bit remains set and its endpoint is enabled, with no further reports.
- R10: After reset every record is zero, the enable mask is zero and both interrupts are low.
- R11: A report with valid low, and a clear of one endpoint, leave the records of the other endpoints unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| rep_valid | input | N_EP | per-endpoint report strobe |
| rep_sec | input | N_EP | single-bit (correctable) error flag |
| rep_ded | input | N_EP | double-bit error flag |
| rep_par | input | N_EP | endpoint is parity-only |
| rep_addr | input | N_EP*ADDR_W | per-endpoint failing address, endpoint i at bits [i*ADDR_W +: ADDR_W] |
| rep_bits | input | N_EP*BIT_W | per-endpoint bit-location field, same packing |
| clr_valid | input | 1 | clear strobe |
| clr_idx | input | IDX_W | endpoint to clear |
| en_we | input | 1 | write strobe for the enable mask |
| en_wdata | input | N_EP | new enable mask |
| rd_idx | input | IDX_W | endpoint shown on the read port |
| rd_ce | output | 1 | selected correctable-pending bit |
| rd_ue | output | 1 | selected uncorrectable-pending bit |
| rd_addr | output | ADDR_W | selected captured address |
| rd_bits | output | BIT_W | selected captured bit field |
| rd_cnt | output | CNT_W | selected report count |
| irq_ce | output | 1 | correctable-error interrupt |
| irq_ue | output | 1 | uncorrectable-error interrupt |

## Verification
Directed sequences cover each flag combination in turn: single only, double only, parity with either flag, and single plus double. Together they separate the correctable path from the uncorrectable path and show that the parity flag overrides correctability. Repeated reports on one endpoint show that the first capture is held and that the count saturates. A clear that lands in the same cycle as a new report shows which of the two takes priority. Masking an endpoint and unmasking it later shows that the mask gates only the interrupts and not the records. A long random phase runs all endpoints at once, with random clears and mask writes, and compares every record and both interrupts against the model on every cycle.

// File: rtl/ecc_agg_pkg.sv
package ecc_agg_pkg;
    parameter int ADDR_W = 16;
    parameter int BIT_W  = 8;
    parameter int CNT_W  = 3;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             ce;
        logic             ue;
        logic [ADDR_W-1:0] addr;
        logic [BIT_W-1:0]  bits;
        logic [CNT_W-1:0]  cnt;
    } ep_rec_t;

    typedef struct packed {
        logic ce;
        logic ue;
    } ev_t;

    function automatic ev_t classify(input logic v, input logic sec,
                                     input logic ded, input logic par);
        ev_t e;
        e.ce = v & sec & ~par;
        e.ue = v & (ded | (par & (sec | ded)));
        return e;
    endfunction

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
        return (c == CNT_MAX) ? c : c + 1'b1;
    endfunction
endpackage

// File: rtl/ecc_agg_slot.sv
module ecc_agg_slot
    import ecc_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              v,
    input  logic              sec,
    input  logic              ded,
    input  logic              par,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BIT_W-1:0]  bits,
    input  logic              clr,
    output ep_rec_t           rec
);
    ep_rec_t base, nxt;
    ev_t     ev;

    always_comb begin
        ev   = classify(v, sec, ded, par);
        base = clr ? '0 : rec;
        nxt  = base;
        if (ev.ce || ev.ue) begin
            if (!base.ce && !base.ue) begin
                nxt.addr = addr;
                nxt.bits = bits;
            end
            nxt.ce  = base.ce | ev.ce;
            nxt.ue  = base.ue | ev.ue;
            nxt.cnt = sat_inc(base.cnt);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rec <= '0;
        else     rec <= nxt;
    end
endmodule

// File: rtl/ecc_agg_irq.sv
module ecc_agg_irq #(
    parameter int N_EP = 8
) (
    input  logic [N_EP-1:0] ce_vec,
    input  logic [N_EP-1:0] ue_vec,
    input  logic [N_EP-1:0] en,
    output logic            irq_ce,
    output logic            irq_ue
);
    assign irq_ce = |(ce_vec & en);
    assign irq_ue = |(ue_vec & en);
endmodule

// File: rtl/ecc_agg_rdmux.sv
module ecc_agg_rdmux
    import ecc_agg_pkg::*;
#(
    parameter int N_EP  = 8,
    localparam int IDX_W = $clog2(N_EP)
) (
    input  ep_rec_t          recs [N_EP],
    input  logic [IDX_W-1:0] idx,
    output ep_rec_t          sel
);
    always_comb begin
        sel = '0;
        for (int i = 0; i < N_EP; i++)
            if (idx == IDX_W'(i)) sel = recs[i];
    end
endmodule

// File: rtl/ecc_err_agg.sv
module ecc_err_agg
    import ecc_agg_pkg::*;
#(
    parameter int N_EP  = 8,
    localparam int IDX_W = $clog2(N_EP)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_EP-1:0]          rep_valid,
    input  logic [N_EP-1:0]          rep_sec,
    input  logic [N_EP-1:0]          rep_ded,
    input  logic [N_EP-1:0]          rep_par,
    input  logic [N_EP*ADDR_W-1:0]   rep_addr,
    input  logic [N_EP*BIT_W-1:0]    rep_bits,
    input  logic                     clr_valid,
    input  logic [IDX_W-1:0]         clr_idx,
    input  logic                     en_we,
    input  logic [N_EP-1:0]          en_wdata,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic                     rd_ce,
    output logic                     rd_ue,
    output logic [ADDR_W-1:0]        rd_addr,
    output logic [BIT_W-1:0]         rd_bits,
    output logic [CNT_W-1:0]         rd_cnt,
    output logic                     irq_ce,
    output logic                     irq_ue
);
    ep_rec_t          recs [N_EP];
    ep_rec_t          sel;
    logic [N_EP-1:0]  ce_vec, ue_vec;
    logic [N_EP-1:0]  en_mask;

    always_ff @(posedge clk) begin
        if (rst)        en_mask <= '0;
        else if (en_we) en_mask <= en_wdata;
    end

    for (genvar g = 0; g < N_EP; g++) begin : g_slot
        ecc_agg_slot u_slot (
            .clk  (clk),
            .rst  (rst),
            .v    (rep_valid[g]),
            .sec  (rep_sec[g]),
            .ded  (rep_ded[g]),
            .par  (rep_par[g]),
            .addr (rep_addr[g*ADDR_W +: ADDR_W]),
            .bits (rep_bits[g*BIT_W +: BIT_W]),
            .clr  (clr_valid && (clr_idx == IDX_W'(g))),
            .rec  (recs[g])
        );
        assign ce_vec[g] = recs[g].ce;
        assign ue_vec[g] = recs[g].ue;
    end

    ecc_agg_irq #(.N_EP(N_EP)) u_irq (
        .ce_vec (ce_vec),
        .ue_vec (ue_vec),
        .en     (en_mask),
        .irq_ce (irq_ce),
        .irq_ue (irq_ue)
    );

    ecc_agg_rdmux #(.N_EP(N_EP)) u_rd (
        .recs (recs),
        .idx  (rd_idx),
        .sel  (sel)
    );

    assign rd_ce   = sel.ce;
    assign rd_ue   = sel.ue;
    assign rd_addr = sel.addr;
    assign rd_bits = sel.bits;
    assign rd_cnt  = sel.cnt;
endmodule

// File: rtl/ecc_agg_chk.sv
module ecc_agg_chk
    import ecc_agg_pkg::*;
#(
    parameter int N_EP  = 8,
    localparam int IDX_W = $clog2(N_EP)
) (
    input logic              clk,
    input logic              rst,
    input logic [N_EP-1:0]   rep_valid,
    input logic [N_EP-1:0]   rep_sec,
    input logic [N_EP-1:0]   rep_par,
    input logic              clr_valid,
    input logic [IDX_W-1:0]  clr_idx,
    input logic              en_we,
    input logic [N_EP-1:0]   en_mask,
    input logic [IDX_W-1:0]  rd_idx,
    input logic              rd_ce,
    input logic              rd_ue,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [CNT_W-1:0]  rd_cnt,
    input logic              irq_ce,
    input logic              irq_ue
);
    // R1, R8: enabled correctable report raises irq_ce next cycle
    a_r1_ce_irq: assert property (@(posedge clk) disable iff (rst)
        (|(rep_valid & rep_sec & ~rep_par & en_mask) && !en_we) |=> irq_ce);

    // R3: parity-only report with the single flag reaches the uncorrectable interrupt
    a_r3_par_ue: assert property (@(posedge clk) disable iff (rst)
        (|(rep_valid & rep_sec & rep_par & en_mask) && !en_we) |=> irq_ue);

    // R5: captured address held while the record stays pending and is not cleared
    a_r5_hold_addr: assert property (@(posedge clk) disable iff (rst)
        ((rd_ce || rd_ue) && !(clr_valid && clr_idx == rd_idx))
        |=> (rd_idx != $past(rd_idx)) || (rd_addr == $past(rd_addr)));

    // R6: saturated count stays saturated until cleared
    a_r6_sat_cnt: assert property (@(posedge clk) disable iff (rst)
        ((rd_cnt == CNT_MAX) && !(clr_valid && clr_idx == rd_idx))
        |=> (rd_idx != $past(rd_idx)) || (rd_cnt == CNT_MAX));

    // R7: clear with no coincident report empties the record
    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_valid && clr_idx == rd_idx && !rep_valid[clr_idx])
        |=> (rd_idx != $past(rd_idx)) || (!rd_ce && !rd_ue && rd_cnt == '0));
endmodule

bind ecc_err_agg ecc_agg_chk #(.N_EP(N_EP)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rep_valid (rep_valid),
    .rep_sec   (rep_sec),
    .rep_par   (rep_par),
    .clr_valid (clr_valid),
    .clr_idx   (clr_idx),
    .en_we     (en_we),
    .en_mask   (en_mask),
    .rd_idx    (rd_idx),
    .rd_ce     (rd_ce),
    .rd_ue     (rd_ue),
    .rd_addr   (rd_addr),
    .rd_cnt    (rd_cnt),
    .irq_ce    (irq_ce),
    .irq_ue    (irq_ue)
);

// File: tb/ecc_err_agg_test.sv
`timescale 1ns/100ps
module ecc_err_agg_test;
    import ecc_agg_pkg::*;
    localparam int N = 8;
    localparam int IW = $clog2(N);
    localparam int CMAX = (1 << CNT_W) - 1;

    logic clk = 0, rst = 1;
    logic [N-1:0] rep_valid = '0, rep_sec = '0, rep_ded = '0, rep_par = '0;
    logic [N*ADDR_W-1:0] rep_addr = '0;
    logic [N*BIT_W-1:0]  rep_bits = '0;
    logic clr_valid = 0, en_we = 0;
    logic [IW-1:0] clr_idx = '0, rd_idx = '0;
    logic [N-1:0] en_wdata = '0;
    logic rd_ce, rd_ue, irq_ce, irq_ue;
    logic [ADDR_W-1:0] rd_addr;
    logic [BIT_W-1:0] rd_bits;
    logic [CNT_W-1:0] rd_cnt;

    always #5 clk = ~clk;

    ecc_err_agg #(.N_EP(N)) uut (.*);

    // behavioural model
    bit m_ce[N], m_ue[N];
    int m_cnt[N];
    int m_addr[N], m_bits[N];
    bit m_en[N];
    int total = 0, bad = 0;
    string phase = "R10";

    task automatic check(string tag, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s (%s) t=%0t actual=%0d expected=%0d", phase, tag, $time, act, exp);
        end
    endtask

    task automatic model_step();
        if (en_we) for (int i = 0; i < N; i++) m_en[i] = en_wdata[i];
        for (int i = 0; i < N; i++) begin
            bit ce_e, ue_e;
            if (clr_valid && clr_idx == IW'(i)) begin
                m_ce[i] = 0; m_ue[i] = 0; m_cnt[i] = 0;
                m_addr[i] = 0; m_bits[i] = 0;
            end
            ce_e = rep_valid[i] && rep_sec[i] && !rep_par[i];
            ue_e = rep_valid[i] && (rep_ded[i] || (rep_par[i] && rep_sec[i]));
            if (ce_e || ue_e) begin
                if (!m_ce[i] && !m_ue[i]) begin
                    m_addr[i] = int'(rep_addr[i*ADDR_W +: ADDR_W]);
                    m_bits[i] = int'(rep_bits[i*BIT_W +: BIT_W]);
                end
                m_ce[i] = m_ce[i] | ce_e;
                m_ue[i] = m_ue[i] | ue_e;
                if (m_cnt[i] < CMAX) m_cnt[i]++;
            end
        end
    endtask

    task automatic compare_all();
        bit ec = 0, eu = 0;
        for (int i = 0; i < N; i++) begin
            ec |= m_ce[i] & m_en[i];
            eu |= m_ue[i] & m_en[i];
        end
        check("R8 irq_ce", irq_ce, ec);
        check("R8 irq_ue", irq_ue, eu);
        for (int i = 0; i < N; i++) begin
            rd_idx = IW'(i);
            #0.5;
            check("R1 ce", rd_ce, m_ce[i]);
            check("R2 ue", rd_ue, m_ue[i]);
            check("R5 addr", rd_addr, m_addr[i]);
            check("R5 bits", rd_bits, m_bits[i]);
            check("R6 cnt", rd_cnt, m_cnt[i]);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        rep_valid = '0; rep_sec = '0; rep_ded = '0; rep_par = '0;
        clr_valid = 0; en_we = 0;
        compare_all();
    endtask

    task automatic report(int i, bit s, bit d, bit p, int a, int b);
        rep_valid[i] = 1; rep_sec[i] = s; rep_ded[i] = d; rep_par[i] = p;
        rep_addr[i*ADDR_W +: ADDR_W] = ADDR_W'(a);
        rep_bits[i*BIT_W +: BIT_W] = BIT_W'(b);
    endtask

    task automatic clear(int i);
        clr_valid = 1; clr_idx = IW'(i);
    endtask

    initial begin
        #(200000 * 10);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_ce[i] = 0; m_ue[i] = 0; m_cnt[i] = 0; m_addr[i] = 0; m_bits[i] = 0; m_en[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        phase = "R10";
        compare_all();

        // R1 and R8: correctable error while masked, then unmask
        phase = "R1";
        report(0, 1, 0, 0, 'h1234, 'h05); tick();
        phase = "R8"; tick();
        en_we = 1; en_wdata = '1; tick();
        // R9: interrupt level persists with no further reports
        phase = "R9"; repeat (4) tick();

        // R2 double-bit
        phase = "R2"; report(1, 0, 1, 0, 'h0042, 'h81); tick();
        // R3 parity endpoint with either flag
        phase = "R3"; report(2, 1, 0, 1, 'h0777, 'h01); report(3, 0, 1, 1, 'h0888, 'h02); tick();
        // R4 both flags
        phase = "R4"; report(4, 1, 1, 0, 'h0abc, 'h11); tick();

        // R5 and R6: repeated reports on one endpoint
        phase = "R5"; report(5, 1, 0, 0, 'h0100, 'h10); tick();
        phase = "R6";
        for (int k = 0; k < 10; k++) begin report(5, k % 2, 1, 0, 'h0200 + k, 'h20 + k); tick(); end

        // R11: clearing one endpoint keeps others; invalid report ignored
        phase = "R11"; clear(5); rep_sec[6] = 1; rep_ded[6] = 1; tick();
        // R7: clear coincident with a report takes the new report as first
        phase = "R7"; report(0, 0, 1, 0, 'h0fff, 'h44); clear(0); tick();
        clear(0); tick();

        // random phase across all endpoints
        phase = "R1 random";
        for (int c = 0; c < 400; c++) begin
            for (int i = 0; i < N; i++)
                if ($urandom_range(3) == 0)
                    report(i, 1'($urandom), 1'($urandom), ($urandom_range(4) == 0),
                           int'($urandom_range(65535)), int'($urandom_range(255)));
            if ($urandom_range(5) == 0) clear(int'($urandom_range(N-1)));
            if ($urandom_range(15) == 0) begin en_we = 1; en_wdata = N'($urandom); end
            tick();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule